// File: doc/BRIEF.md
# I2C Serial Memory Read Target

This block is the two-wire serial bus target in front of a byte-wide storage array of 512 locations. It watches the clock and data lines through a synchronizer, recognizes start and stop conditions, and answers a fixed device address. A write-direction device byte is followed by a two-byte word address, high byte first, which sets a persistent address counter. A read-direction device byte makes the target send bytes from that counter, one per acknowledge from the bus master, wrapping from the top of the array back to zero.

If the master ends the address phase with a stop instead of a repeated start, the target keeps the new address and does nothing more, so a later plain read begins there. The data line is driven open-drain style: the block only ever asserts a pull-low enable and reads the wire back. Storage is a synchronous register array filled at reset with a computed pattern.

The controller states are: ST_IDLE (ignore the bus until a start), ST_DEV_RX (shift in the device byte), ST_DEV_ACK, ST_AHI_RX / ST_AHI_ACK (high address byte), ST_ALO_RX / ST_ALO_ACK (low address byte, counter loaded at the end of its acknowledge), ST_HOLD (address loaded, waiting for a repeated start or a stop), ST_RD_TX (shift out a data byte) and ST_RD_ACK (master's continue-or-stop bit). A start moves any state to ST_DEV_RX; a stop moves any state to ST_IDLE. A matching device byte leads to ST_DEV_ACK, others to ST_IDLE; from ST_DEV_ACK the direction bit picks ST_RD_TX or ST_AHI_RX; ST_RD_ACK goes to ST_RD_TX on a master acknowledge and to ST_IDLE otherwise.

Top module: `i2c_mem_target`

## Requirements
- R1: A start is SDA falling while SCL is high and a stop is SDA rising while SCL is high; SDA is sampled on SCL rising edges; the target only pulls SDA low (sda_drive_low_o), and changes that drive only while SCL is low, except for releasing it at a start or stop.
- R2: A device byte of 0xAE (write) or 0xAF (read), sent MSB first, is acknowledged by holding SDA low through the ninth clock; any other value is not acknowledged and the following bytes are ignored until the next start.
- R3: After 0xAE the target acknowledges two address bytes, high byte first; the word address is bit 0 of the high byte above the eight bits of the low byte, and bits 7..1 of the high byte have no effect.
- R4: A random read (address phase, repeated start, 0xAF) is acknowledged and followed by eight data bits, MSB first, from the loaded address.
- R5: A stop in place of the repeated start only loads the counter; a later read that begins directly with 0xAF returns data from that address.
- R6: The counter advances by one for every data byte sent and keeps its value across stops, so consecutive current-address reads continue where the last one ended.
- R7: A master acknowledge (SDA low) in the ninth clock of a read makes the target send the byte at the next address; SDA high there followed by a stop ends the read with SDA released.
- R8: Reading past address 511 continues at address 0.
- R9: After a stop the target drives nothing and acknowledges nothing until a new start.
- R10: A start or stop inside a byte aborts it; a start restarts device-byte reception, and the address counter keeps its last loaded value.
- R11: After reset SDA is released and the counter is 0; location a holds a[7:0] XOR 0xA5 when a[8] is 1 and a[7:0] XOR 0x3C when a[8] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the wire |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_drive_low_o | output | 1 | Pull-low enable for the data line |

## Verification
Random reads of random length at random addresses are interleaved with set-address-then-read and plain current-address reads, so that a counter that fails to persist, advances wrongly, or loads at the wrong moment produces a mismatched byte. Directed cases read across the 511-to-0 boundary, send a high address byte with all upper bits set, send a wrong device byte followed by a correct one without a start, clock bytes after a stop, and abort an address byte and a device byte halfway; each of these separates one specific decode or ignore rule from the ordinary read path.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_RX,
        ST_DEV_ACK,
        ST_AHI_RX,
        ST_AHI_ACK,
        ST_ALO_RX,
        ST_ALO_ACK,
        ST_HOLD,
        ST_RD_TX,
        ST_RD_ACK
    } tgt_state_e;

    // Reset fill pattern of the storage array
    function automatic logic [7:0] fill_byte(input logic [8:0] a);
        return a[7:0] ^ (a[8] ? 8'hA5 : 8'h3C);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [SYNC_STAGES-1:0] scl_sr;
    logic [SYNC_STAGES-1:0] sda_sr;
    logic scl_p;
    logic sda_p;
    logic scl_s;

    assign scl_s = scl_sr[SYNC_STAGES-1];
    assign sda_q = sda_sr[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
            scl_p  <= scl_s;
            sda_p  <= sda_q;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign bus_start = scl_s & scl_p & sda_p & ~sda_q;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/i2c_addr_counter.sv
module i2c_addr_counter #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] count
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (inc) begin
            count <= (count == LAST) ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array
    import i2c_mem_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= fill_byte(9'(i));
            end
            rdata <= '0;
        end else begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter logic [6:0] DEV_ID      = 7'h57,
    parameter int         MEM_DEPTH   = 512,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_drive_low_o
);
    localparam int AW   = $clog2(MEM_DEPTH);
    localparam int HI_W = AW - 8;

    tgt_state_e      state, state_nx;
    logic            sda_q, scl_rise, scl_fall, bus_start, bus_stop;
    logic [3:0]      bit_cnt;
    logic [7:0]      shreg;
    logic [HI_W-1:0] hi_q;
    logic [7:0]      tx_q;
    logic            mack_q;
    logic [AW-1:0]   addr_cnt;
    logic [7:0]      mem_rdata;
    logic            cnt_load, cnt_inc;
    logic            rx_state, byte_in_done;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_addr_counter #(.DEPTH(MEM_DEPTH), .AW(AW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load),
        .load_val({hi_q, shreg}), .inc(cnt_inc), .count(addr_cnt)
    );

    i2c_mem_array #(.DEPTH(MEM_DEPTH), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .addr(addr_cnt), .rdata(mem_rdata)
    );

    assign rx_state     = (state == ST_DEV_RX) || (state == ST_AHI_RX) || (state == ST_ALO_RX);
    assign byte_in_done = scl_fall && (bit_cnt == 4'd8);
    assign cnt_load     = (state == ST_ALO_ACK) && scl_fall && !bus_start && !bus_stop;
    assign cnt_inc      = (state == ST_RD_TX) && scl_fall && (bit_cnt == 4'd7)
                          && !bus_start && !bus_stop;

    // Transition logic
    always_comb begin
        state_nx = state;
        if (bus_start) begin
            state_nx = ST_DEV_RX;
        end else if (bus_stop) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_DEV_RX:  if (byte_in_done)
                                state_nx = (shreg[7:1] == DEV_ID) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK: if (scl_fall)
                                state_nx = shreg[0] ? ST_RD_TX : ST_AHI_RX;
                ST_AHI_RX:  if (byte_in_done) state_nx = ST_AHI_ACK;
                ST_AHI_ACK: if (scl_fall) state_nx = ST_ALO_RX;
                ST_ALO_RX:  if (byte_in_done) state_nx = ST_ALO_ACK;
                ST_ALO_ACK: if (scl_fall) state_nx = ST_HOLD;
                ST_HOLD:    state_nx = ST_HOLD;
                ST_RD_TX:   if (scl_fall && bit_cnt == 4'd7) state_nx = ST_RD_ACK;
                ST_RD_ACK:  if (scl_fall) state_nx = mack_q ? ST_RD_TX : ST_IDLE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            hi_q    <= '0;
            tx_q    <= '0;
            mack_q  <= 1'b0;
        end else begin
            state <= state_nx;

            if (bus_start || state_nx != state) begin
                bit_cnt <= '0;
            end else if (rx_state && scl_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
            end else if (state == ST_RD_TX && scl_fall) begin
                bit_cnt <= bit_cnt + 1'b1;
            end

            if (rx_state && scl_rise && !bus_start && !bus_stop) begin
                shreg <= {shreg[6:0], sda_q};
            end

            if (state == ST_AHI_RX && byte_in_done) begin
                hi_q <= shreg[HI_W-1:0];
            end

            if (state_nx == ST_RD_TX && state != ST_RD_TX) begin
                tx_q <= mem_rdata;
            end else if (state == ST_RD_TX && scl_fall) begin
                tx_q <= {tx_q[6:0], 1'b0};
            end

            if (state == ST_RD_ACK && scl_rise) begin
                mack_q <= ~sda_q;
            end
        end
    end

    // Output drive
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK: sda_drive_low_o = 1'b1;
            ST_RD_TX:                           sda_drive_low_o = ~tx_q[7];
            default:                            sda_drive_low_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
    import i2c_mem_pkg::*;
#(
    parameter int MEM_DEPTH = 512,
    parameter int AW        = $clog2(MEM_DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          bus_start,
    input logic          bus_stop,
    input logic          sda_drive_low_o,
    input logic          cnt_inc,
    input logic          cnt_load,
    input logic [AW-1:0] addr_cnt,
    input tgt_state_e    state
);
    localparam logic [AW-1:0] LAST = AW'(MEM_DEPTH - 1);

    AST_DRIVE_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_drive_low_o) && !$past(bus_start) && !$past(bus_stop)) |-> !scl_i); // R1

    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_drive_low_o); // R9

    AST_COUNTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && addr_cnt != LAST) |=> addr_cnt == $past(addr_cnt) + 1'b1); // R6

    AST_COUNTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && addr_cnt == LAST) |=> addr_cnt == '0); // R8

    AST_COUNTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_inc && !cnt_load) |=> $stable(addr_cnt)); // R10

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> state == ST_DEV_RX); // R10

endmodule

bind i2c_mem_target i2c_mem_target_chk #(.MEM_DEPTH(MEM_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .bus_start(bus_start),
    .bus_stop(bus_stop), .sda_drive_low_o(sda_drive_low_o),
    .cnt_inc(cnt_inc), .cnt_load(cnt_load), .addr_cnt(addr_cnt), .state(state)
);

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_bus;
    logic sda_drive_low_o;
    int   n_checks = 0;
    int   n_fail = 0;
    int   m_addr = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = ~(m_low | sda_drive_low_o);

    i2c_mem_target i_i2c_mem_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_drive_low_o(sda_drive_low_o)
    );

    function automatic int exp_byte(int a);
        int w = a % 512;
        return (w & 255) ^ ((w >= 256) ? 8'hA5 : 8'h3C);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; q(); scl = 1'b1; q(); m_low = 1'b1; q(); scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; q(); scl = 1'b1; q(); m_low = 1'b0; q();
    endtask

    task automatic wbits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
        end
    endtask

    task automatic wbyte(logic [7:0] b, output bit ack);
        wbits(b, 8);
        m_low = 1'b0; q(); scl = 1'b1; q();
        ack = ~sda_bus;
        q(); scl = 1'b0; q();
    endtask

    task automatic rbyte(bit mack, output logic [7:0] d);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            q(); scl = 1'b1; q(); d[i] = sda_bus; q(); scl = 1'b0;
        end
        m_low = mack; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
        m_low = 1'b0;
    endtask

    task automatic addr_phase(int a, logic [7:0] hi_extra);
        bit ack;
        bus_start();
        wbyte(8'hAE, ack); chk("R2 write device ack", ack, 1);
        wbyte(8'((a >> 8) & 1) | hi_extra, ack); chk("R3 high address ack", ack, 1);
        wbyte(8'(a & 255), ack); chk("R3 low address ack", ack, 1);
    endtask

    // read n bytes after a (repeated) start, 0xAF, from the model counter
    task automatic read_run(int n, string req);
        bit ack;
        logic [7:0] d;
        wbyte(8'hAF, ack); chk("R4 read device ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(i < n - 1, d);
            chk(req, int'(d), exp_byte(m_addr));
            m_addr = (m_addr + 1) % 512;
        end
        bus_stop();
        chk("R7 SDA released after stop", int'(sda_bus), 1);
    endtask

    initial begin
        bit ack;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11 reset state
        chk("R11 SDA released after reset", int'(sda_bus), 1);
        bus_start(); read_run(2, "R11 reset contents R6 current read");
        bus_start(); read_run(1, "R6 counter persists across stop");

        // R4 random read
        addr_phase(16'h0A3, 8'h00); bus_start(); m_addr = 16'h0A3;
        read_run(1, "R4 random read data");

        // R5 set current address then current read
        addr_phase(16'h17C, 8'h00); bus_stop(); m_addr = 16'h17C;
        bus_start(); read_run(3, "R5 R7 set address then sequential read");

        // R8 wrap
        addr_phase(16'h1FE, 8'h00); bus_start(); m_addr = 16'h1FE;
        read_run(4, "R8 wrap past 511");

        // R3 upper high bits ignored
        addr_phase(16'h110, 8'hFE); bus_start(); m_addr = 16'h110;
        read_run(1, "R3 high byte bits 7..1 ignored");

        // R2 wrong device byte, later bytes ignored
        bus_start();
        wbyte(8'hA0, ack); chk("R2 wrong device not acked", ack, 0);
        wbyte(8'hAF, ack); chk("R2 bytes ignored until start", ack, 0);
        bus_stop();

        // R9 no start after stop
        wbyte(8'hAE, ack); chk("R9 ignored without start", ack, 0);
        chk("R9 SDA released", int'(sda_bus), 1);
        bus_start(); read_run(1, "R9 counter untouched by ignored bytes");

        // R10 stop inside low address byte
        bus_start();
        wbyte(8'hAE, ack); wbyte(8'h01, ack);
        wbits(8'h55, 4);
        bus_stop();
        bus_start(); read_run(1, "R10 aborted address leaves counter");

        // R10 start inside device byte
        bus_start();
        wbits(8'hAE, 4);
        bus_start(); read_run(1, "R10 start mid byte restarts");

        // random mix
        for (int it = 0; it < 16; it++) begin
            int a = int'($urandom_range(0, 511));
            int n = int'($urandom_range(1, 4));
            int mode = int'($urandom_range(0, 2));
            if (mode == 0) begin
                addr_phase(a, 8'h00); bus_start(); m_addr = a;
                read_run(n, "R4 R7 random read");
            end else if (mode == 1) begin
                addr_phase(a, 8'h00); bus_stop(); m_addr = a;
                bus_start(); read_run(n, "R5 R7 set address read");
            end else begin
                bus_start(); read_run(n, "R6 current address read");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule